// File: doc/BRIEF.md
# Privileged Region-Start Register Access Gate

This block owns one 64-bit register that holds the start address of a memory region together with an enable flag, and it decides, for every read or write request made to that register, what the request turns into. The decision depends on the current privilege level (0 to 3), on whether levels 2 and 3 exist, on the security state, on coarse and fine-grained trap controls, and on two conditions that turn a trap into an undefined result. Each request gets exactly one outcome: undefined, trap to level 2, trap to level 3, or performed.

The outcome is a one-hot 4-bit vector that is valid in the same cycle as the request strobe. Traps carry the exception class 0x18. A performed write lands in the register at the next rising clock edge. A read that is not performed returns zero. The read view always shows the fixed-zero fields as zero and hides address bits above the selected physical-address width. When descriptors are not supported, the register reads as zero and ignores writes.

Top module: `privreg_gate`

## Requirements
- R1: When the feature is absent (`feat_present`=0), or the request comes from level 0, the outcome is undefined.
- R2: At level 1 the first matching rule wins: (a) level 3 present with `undef_prio` and `el3_trap` gives undefined; (b) level 3 present with `secure`=1 gives undefined; (c) `el2_enabled` with `el2_trap` traps to level 2; (d) the fine-grained test traps to level 2; (e) `el3_trap` traps to level 3; (f) otherwise the access is performed. Without level 3, rules (a) and (b) do not apply.
- R3: The fine-grained test passes only when all of these hold: `el2_enabled`, `fg_feat`, either level 3 is absent or `fg_enable`=1, and the request's own bit is set (`fg_rd_trap` for reads, `fg_wr_trap` for writes). The other direction's bit has no effect.
- R4: Where `el3_trap` would trap to level 3 (at level 1 or level 2), `dbg_undef`=1 makes the outcome undefined instead.
- R5: At level 2 the order is: level 3 present with `secure` gives undefined; then level 3 present with `undef_prio` and `el3_trap` gives undefined; then level 3 present with `el3_trap` traps to level 3; otherwise the access is performed. The level-2 trap bits have no effect.
- R6: At level 3, `secure`=1 gives undefined, and any other request is performed.
- R7: `outcome` has bit 0 for undefined, bit 1 for a trap to level 2, bit 2 for a trap to level 3, and bit 3 for performed. Exactly one bit is set in the cycle `req_valid` is high, and all bits are zero otherwise. `exc_class` is 0x18 for either trap and 0 in every other case.
- R8: A performed write stores data bits 55:16 (address) and bit 0 (valid). From the next cycle, reads return bits 63:56 and 15:1 as zero.
- R9: `pa_sel` picks the address width: 0 selects 48 bits, 1 selects 52 bits, and 2 or 3 select 56 bits. Stored address bits at or above the chosen width read as zero.
- R10: Reset (synchronous, active-low) clears the valid bit. The address field keeps no defined reset value.
- R11: When `desc_support`=0, reads return zero and writes leave the register unchanged.
- R12: A write whose outcome is not "performed" leaves the register unchanged. A read whose outcome is not "performed" returns zero on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data |
| cur_level | input | 2 | Current privilege level 0..3 |
| feat_present | input | 1 | Feature implemented |
| el2_enabled | input | 1 | Level 2 enabled in the current state |
| el3_present | input | 1 | Level 3 exists |
| secure | input | 1 | 1 = secure state |
| undef_prio | input | 1 | Undefined takes priority over the level-3 trap |
| dbg_undef | input | 1 | Turns a level-3 trap into undefined |
| el3_trap | input | 1 | Level-3 trap control |
| el2_trap | input | 1 | Level-2 coarse trap control |
| fg_feat | input | 1 | Fine-grained trap feature present |
| fg_enable | input | 1 | Level-3 enable for fine-grained traps |
| fg_rd_trap | input | 1 | Fine-grained trap for reads |
| fg_wr_trap | input | 1 | Fine-grained trap for writes |
| pa_sel | input | 2 | Physical-address width selector |
| desc_support | input | 1 | Selected region descriptor is supported |
| outcome | output | 4 | One-hot result of the request |
| exc_class | output | 6 | Exception class for traps |
| rdata | output | 64 | Read data |

## Verification
The assertions take for granted that all control inputs and the request fields are stable at the rising clock edge and hold for the whole cycle. The same-cycle outcome and read-data checks compare values that are combinational in those inputs. The register-hold check assumes that `pa_sel` and `desc_support` do not change the stored state, only the view. The bench changes every input only on the falling edge. It holds each request for exactly one cycle. It sweeps every combination of level, direction and control bits, so that no input changes while an edge samples it.

// File: rtl/privreg_gate_pkg.sv
// Package: shared types for the privileged register access gate.
// Assumes: one-hot outcome encoding is fixed and decoded by neighbours.
package privreg_gate_pkg;

    // One-hot outcome of a single request
    typedef enum logic [3:0] {
        OUT_NONE  = 4'b0000,
        OUT_UNDEF = 4'b0001,
        OUT_TRAP2 = 4'b0010,
        OUT_TRAP3 = 4'b0100,
        OUT_DONE  = 4'b1000
    } outcome_e;

    // Configuration and trap controls sampled with each request
    typedef struct packed {
        logic feat;
        logic el2_en;
        logic el3_has;
        logic secure;
        logic undef_prio;
        logic dbg_undef;
        logic el3_trap;
        logic el2_trap;
        logic fg_feat;
        logic fg_en;
        logic fg_rd;
        logic fg_wr;
    } ctrl_t;

endpackage

// File: rtl/gate_policy.sv
// Module: gate_policy
// Purely combinational priority resolver. It maps privilege level, request
// direction and control bits to one outcome. Assumes all inputs are stable
// for the cycle in which the request is presented.
module gate_policy
    import privreg_gate_pkg::*;
(
    input  logic [1:0] level,
    input  logic       is_write,
    input  ctrl_t      ctl,
    output outcome_e   res
);

    logic fg_hit;
    logic prio_undef;
    logic el3_route;

    // Fine-grained trap test; the direction picks its own bit
    always_comb begin
        fg_hit = ctl.el2_en && ctl.fg_feat && (!ctl.el3_has || ctl.fg_en)
                 && (is_write ? ctl.fg_wr : ctl.fg_rd);
    end

    // Shared level-3 terms
    always_comb begin
        prio_undef = ctl.el3_has && ctl.undef_prio && ctl.el3_trap;
        el3_route  = ctl.el3_has && ctl.el3_trap;
    end

    // Per-level priority chain, first match wins
    always_comb begin
        res = OUT_DONE;
        if (!ctl.feat) begin
            res = OUT_UNDEF;
        end else begin
            unique case (level)
                2'd0: res = OUT_UNDEF;
                2'd1: begin
                    if (prio_undef)                       res = OUT_UNDEF;
                    else if (ctl.el3_has && ctl.secure)   res = OUT_UNDEF;
                    else if (ctl.el2_en && ctl.el2_trap)  res = OUT_TRAP2;
                    else if (fg_hit)                      res = OUT_TRAP2;
                    else if (el3_route)                   res = ctl.dbg_undef ? OUT_UNDEF : OUT_TRAP3;
                    else                                  res = OUT_DONE;
                end
                2'd2: begin
                    if (ctl.el3_has && ctl.secure)        res = OUT_UNDEF;
                    else if (prio_undef)                  res = OUT_UNDEF;
                    else if (el3_route)                   res = ctl.dbg_undef ? OUT_UNDEF : OUT_TRAP3;
                    else                                  res = OUT_DONE;
                end
                default: begin
                    res = ctl.secure ? OUT_UNDEF : OUT_DONE;
                end
            endcase
        end
    end

endmodule

// File: rtl/gate_store.sv
// Module: gate_store
// Holds the region start address and valid flag and builds the read view.
// Assumes wr_en is already qualified by the access decision. The address
// field has no reset; only the valid flag is cleared.
module gate_store #(
    parameter int DATA_W  = 64,
    parameter int ADDR_LO = 16,
    parameter int ADDR_HI = 55,
    parameter int PA_NARROW = 48,
    parameter int PA_MID    = 52,
    parameter int PA_WIDE   = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [1:0]        pa_sel,
    output logic [DATA_W-1:0] view
);

    localparam int FIELD_W = ADDR_HI - ADDR_LO + 1;

    logic [FIELD_W-1:0] addr_q;
    logic               valid_q;
    int                 pa_limit;

    // Valid flag: cleared by reset, loaded by a granted write
    always_ff @(posedge clk) begin
        if (!rst_n)     valid_q <= 1'b0;
        else if (wr_en) valid_q <= wdata[0];
    end

    // Address field: loaded by a granted write, no reset value
    always_ff @(posedge clk) begin
        if (wr_en) addr_q <= wdata[ADDR_HI:ADDR_LO];
    end

    // Width selector to a bit limit
    always_comb begin
        unique case (pa_sel)
            2'd0:    pa_limit = PA_NARROW;
            2'd1:    pa_limit = PA_MID;
            default: pa_limit = PA_WIDE;
        endcase
    end

    // Read view: fixed-zero fields, masked address, valid flag
    always_comb begin
        view    = '0;
        view[0] = valid_q;
        for (int b = ADDR_LO; b <= ADDR_HI; b++) begin
            view[b] = addr_q[b-ADDR_LO] && (b < pa_limit);
        end
    end

    assert_reset_clears_valid_R10: assert property (@(posedge clk)
        disable iff (!rst_n) $past(!rst_n) |-> !view[0]);

    assert_view_width_R9: assert property (@(posedge clk)
        disable iff (!rst_n) (pa_sel == 2'd0) |-> (view[ADDR_HI:PA_NARROW] == '0));

endmodule

// File: rtl/privreg_gate.sv
// Module: privreg_gate (top)
// Resolves every read/write request to the region-start register into one
// outcome, performs granted writes and returns granted reads. Assumes the
// request and all controls are stable around the rising clock edge.
module privreg_gate
    import privreg_gate_pkg::*;
#(
    parameter int          DATA_W  = 64,
    parameter int          EC_W    = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        cur_level,
    input  logic              feat_present,
    input  logic              el2_enabled,
    input  logic              el3_present,
    input  logic              secure,
    input  logic              undef_prio,
    input  logic              dbg_undef,
    input  logic              el3_trap,
    input  logic              el2_trap,
    input  logic              fg_feat,
    input  logic              fg_enable,
    input  logic              fg_rd_trap,
    input  logic              fg_wr_trap,
    input  logic [1:0]        pa_sel,
    input  logic              desc_support,
    output logic [3:0]        outcome,
    output logic [EC_W-1:0]   exc_class,
    output logic [DATA_W-1:0] rdata
);

    ctrl_t             ctl;
    outcome_e          decided;
    logic              granted;
    logic [DATA_W-1:0] view;

    // Gather controls into one bundle
    always_comb begin
        ctl = '{feat: feat_present, el2_en: el2_enabled, el3_has: el3_present,
                secure: secure, undef_prio: undef_prio, dbg_undef: dbg_undef,
                el3_trap: el3_trap, el2_trap: el2_trap, fg_feat: fg_feat,
                fg_en: fg_enable, fg_rd: fg_rd_trap, fg_wr: fg_wr_trap};
    end

    gate_policy u_policy (
        .level    (cur_level),
        .is_write (req_write),
        .ctl      (ctl),
        .res      (decided)
    );

    gate_store #(.DATA_W(DATA_W)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (granted && req_write && desc_support),
        .wdata  (req_wdata),
        .pa_sel (pa_sel),
        .view   (view)
    );

    // Outcome, class and grant qualified by the request strobe
    always_comb begin
        outcome   = req_valid ? decided : OUT_NONE;
        granted   = req_valid && (decided == OUT_DONE);
        exc_class = (req_valid && (decided == OUT_TRAP2 || decided == OUT_TRAP3))
                    ? TRAP_EC : '0;
    end

    // Read data only for a granted read of a supported descriptor
    always_comb begin
        rdata = (granted && !req_write && desc_support) ? view : '0;
    end

    assert_level0_undef_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (cur_level == 2'd0 || !feat_present)) |-> (outcome == 4'b0001));

    assert_l3_secure_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && feat_present && cur_level == 2'd3 && secure) |-> (outcome == 4'b0001));

    assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ($countones(outcome) == 1));

    assert_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (outcome == 4'b0000 && exc_class == '0));

    assert_trap_class_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (outcome[1] || outcome[2]) |-> (exc_class == 6'h18));

    assert_nodesc_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !desc_support |-> (rdata == '0));

    assert_denied_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !outcome[3]) |-> (rdata == '0));

    assert_denied_write_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && !outcome[3]) |=> $stable(u_store.valid_q));

endmodule

// File: tb/privreg_gate_test.sv
`timescale 1ns/1ps
module privreg_gate_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [63:0] req_wdata = '0;
    logic [1:0]  cur_level = '0;
    logic [11:0] ctl = '0;
    logic [1:0]  pa_sel = '0;
    logic        desc_support = 1'b1;
    logic [3:0]  outcome;
    logic [5:0]  exc_class;
    logic [63:0] rdata;

    int checks = 0, errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    privreg_gate uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_wdata(req_wdata), .cur_level(cur_level),
        .feat_present(ctl[11]), .el2_enabled(ctl[10]), .el3_present(ctl[9]),
        .secure(ctl[8]), .undef_prio(ctl[7]), .dbg_undef(ctl[6]),
        .el3_trap(ctl[5]), .el2_trap(ctl[4]), .fg_feat(ctl[3]),
        .fg_enable(ctl[2]), .fg_rd_trap(ctl[1]), .fg_wr_trap(ctl[0]),
        .pa_sel(pa_sel), .desc_support(desc_support),
        .outcome(outcome), .exc_class(exc_class), .rdata(rdata)
    );

    // Directed vectors: {level, write, ctrl[11:0], expected outcome}
    localparam logic [18:0] VEC [10] = '{
        {2'd1, 1'b0, 12'b1110_0000_0000, 4'b1000},  // R2 plain grant
        {2'd1, 1'b0, 12'b1110_1011_0000, 4'b0001},  // R2 priority undef beats level-2 trap
        {2'd1, 1'b0, 12'b1110_0011_0000, 4'b0010},  // R2 coarse trap before level-3 trap
        {2'd1, 1'b0, 12'b1110_0000_1110, 4'b0010},  // R3 read fine-grained trap
        {2'd1, 1'b1, 12'b1110_0000_1110, 4'b1000},  // R3 read bit ignored for write
        {2'd1, 1'b1, 12'b1110_0110_1001, 4'b0001},  // R4 fg blocked, dbg turns level-3 trap undef
        {2'd2, 1'b0, 12'b1111_0010_0000, 4'b0001},  // R5 secure first
        {2'd2, 1'b0, 12'b1110_0011_0000, 4'b0100},  // R5 level-3 trap, level-2 trap ignored
        {2'd3, 1'b0, 12'b1011_0000_0000, 4'b0001},  // R6 secure at level 3
        {2'd1, 1'b0, 12'b1001_0000_0000, 4'b1000}   // R2 secure ignored without level 3
    };

    // Independent reference of the priority rules
    function automatic logic [3:0] ref_out(input logic [1:0] lv, input logic wr,
                                           input logic [11:0] c);
        logic feat, e2, e3, sec, pr, dbg, t3, t2, ff, fe, fr, fw, fg;
        {feat, e2, e3, sec, pr, dbg, t3, t2, ff, fe, fr, fw} = c;
        fg = e2 && ff && (!e3 || fe) && (wr ? fw : fr);
        if (!feat || lv == 2'd0) return 4'b0001;
        if (lv == 2'd1) begin
            if (e3 && pr && t3) return 4'b0001;
            if (e3 && sec)      return 4'b0001;
            if (e2 && t2)       return 4'b0010;
            if (fg)             return 4'b0010;
            if (e3 && t3)       return dbg ? 4'b0001 : 4'b0100;
            return 4'b1000;
        end
        if (lv == 2'd2) begin
            if (e3 && sec)      return 4'b0001;
            if (e3 && pr && t3) return 4'b0001;
            if (e3 && t3)       return dbg ? 4'b0001 : 4'b0100;
            return 4'b1000;
        end
        return sec ? 4'b0001 : 4'b1000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle request: drive on falling edge, sample 1 ns later
    task automatic request(input logic [1:0] lv, input logic wr, input logic [63:0] d,
                           input logic [11:0] c);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_wdata = d; cur_level = lv; ctl = c;
        #1;
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        #1;
    endtask

    localparam logic [11:0] OPEN = 12'b1010_0000_0000;  // level 3 present, non-secure

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;
        // R7 idle after reset
        check(outcome == 4'b0000 && exc_class == 6'd0 && rdata == 64'd0, "R7 idle",
              {52'd0, outcome, exc_class, 2'b0}, 64'd0);
        // R10 valid cleared after reset
        request(2'd3, 1'b0, '0, OPEN);
        check(rdata[0] == 1'b0 && outcome == 4'b1000, "R10 valid after reset",
              rdata, 64'd0);

        // Directed table
        foreach (VEC[i]) begin
            logic [3:0] exp;
            exp = VEC[i][3:0];
            request(VEC[i][18:17], VEC[i][16], '0, VEC[i][15:4]);
            check(outcome == exp, $sformatf("R2-R6 vector %0d", i), outcome, exp);
        end

        // Exhaustive sweep against the reference (R1..R7)
        for (int i = 0; i < 32768; i++) begin
            logic [3:0] exp;
            logic [5:0] ec;
            logic [14:0] v;
            v = i[14:0];
            exp = ref_out(v[1:0], v[2], v[14:3]);
            ec  = (exp == 4'b0010 || exp == 4'b0100) ? 6'h18 : 6'h00;
            request(v[1:0], v[2], '0, v[14:3]);
            check(outcome == exp && exc_class == ec, "R1 R2 R3 R4 R5 R6 R7 sweep",
                  {outcome, exc_class}, {exp, ec});
        end

        // R8 R9 write then read views
        request(2'd3, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, OPEN);
        pa_sel = 2'd2;
        request(2'd3, 1'b0, '0, OPEN);
        check(rdata == 64'h00FF_FFFF_FFFF_0001, "R8 layout 56-bit", rdata, 64'h00FF_FFFF_FFFF_0001);
        pa_sel = 2'd0; #0.1;
        check(rdata == 64'h0000_FFFF_FFFF_0001, "R9 48-bit", rdata, 64'h0000_FFFF_FFFF_0001);
        pa_sel = 2'd1; #0.1;
        check(rdata == 64'h000F_FFFF_FFFF_0001, "R9 52-bit", rdata, 64'h000F_FFFF_FFFF_0001);
        pa_sel = 2'd3; #0.1;
        check(rdata == 64'h00FF_FFFF_FFFF_0001, "R9 sel 3", rdata, 64'h00FF_FFFF_FFFF_0001);

        // R12 denied write from level 0, then read back
        request(2'd0, 1'b1, 64'h0, OPEN);
        request(2'd3, 1'b0, '0, OPEN);
        check(rdata == 64'h00FF_FFFF_FFFF_0001, "R12 denied write", rdata, 64'h00FF_FFFF_FFFF_0001);
        // R12 denied read returns zero
        request(2'd3, 1'b0, '0, 12'b1011_0000_0000);
        check(rdata == 64'd0 && outcome == 4'b0001, "R12 denied read", rdata, 64'd0);

        // R11 unsupported descriptor: reads zero, writes ignored
        desc_support = 1'b0;
        request(2'd3, 1'b1, 64'h0012_3456_7800_0000, OPEN);
        request(2'd3, 1'b0, '0, OPEN);
        check(rdata == 64'd0, "R11 read zero", rdata, 64'd0);
        desc_support = 1'b1; #0.1;
        check(rdata == 64'h00FF_FFFF_FFFF_0001, "R11 write ignored", rdata, 64'h00FF_FFFF_FFFF_0001);

        // R8 new value visible next cycle
        request(2'd2, 1'b1, 64'hAB12_3456_789A_FFFE, OPEN);
        request(2'd2, 1'b0, '0, OPEN);
        check(rdata == 64'h0012_3456_789A_0000, "R8 rewrite", rdata, 64'h0012_3456_789A_0000);

        // R10 reset clears valid after it was set
        request(2'd3, 1'b1, 64'h0000_0000_0001_0001, OPEN);
        idle();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        request(2'd3, 1'b0, '0, OPEN);
        check(rdata[0] == 1'b0, "R10 valid cleared", rdata, 64'd0);
        idle();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule